// File: doc/BRIEF.md
# Four-Way Recency Order Tracker

This block holds the replacement state of a set-associative cache with four ways per set. For every set it stores the exact recency ranking of the four ways, from the most recently used at rank 0 to the least recently used at the last rank. A cache controller presents each access as a set index, a hit/miss flag and, on a hit, the way that hit. The block returns the least recently used way of the addressed set as the victim to fill on a miss.

The victim and the full ranking of the addressed set are combinational functions of the set index and the stored state. When the access strobe is high, the ranking is rewritten at the next rising clock edge. On a hit, the hitting way moves to rank 0 and the others keep their relative order. On a miss, the way at the last rank is the one replaced, so it moves to rank 0.

The access pins are a plain strobe with no handshake. The tracker accepts one access on every cycle and never applies back-pressure. It holds no tags and no data. It does not decide hit or miss; the controller does that.

Top module: `lru_order_tracker`

## Requirements
- R1: After reset every set holds the ranking way 0, 1, 2, 3 from rank 0 to rank 3, so the victim of every set is way 3.
- R2: `victim_way` is the way at the last rank of the set selected by `acc_set`. It follows `acc_set` in the same cycle, with no clock edge needed.
- R3: A hit access (`acc_valid`=1, `acc_hit`=1) on way w moves w to rank 0 at the next rising edge. The ways that were ahead of w shift back by one rank, and the ways behind w keep their ranks. For example, (0,1,2,3) with a hit on 2 gives (2,0,1,3), and a hit on 1 then gives (1,2,0,3).
- R4: A miss access (`acc_valid`=1, `acc_hit`=0) moves the way at the last rank to rank 0 and shifts every other way back by one. `acc_way` is ignored on a miss. For example, (1,2,0,3) gives (3,1,2,0).
- R5: A hit on the way already at rank 0 leaves the ranking unchanged.
- R6: While `acc_valid` is 0, no ranking changes, whatever `acc_hit` and `acc_way` carry.
- R7: An access changes only the ranking of the set it addresses. Every other set keeps its ranking.
- R8: The ranking of every set is always a permutation of the ways 0 to 3.
- R9: `set_order` bits [2k+1:2k] hold the way number at rank k of the addressed set, with rank 0 the most recent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe; the ranking updates at the edge while high |
| acc_set | input | 4 | Set index of the access and of the outputs |
| acc_hit | input | 1 | 1 = hit on `acc_way`, 0 = miss |
| acc_way | input | 2 | Way that hit; ignored on a miss |
| victim_way | output | 2 | Least recently used way of the addressed set |
| set_order | output | 8 | Ranking of the addressed set, field k = way at rank k |

## Verification
The bench replays the fixed sequence hit 2, hit 1, miss, hit on the front way. A design that rotated the whole list, or swapped only two entries, would show a wrong middle rank there. Misses are driven with `acc_way` pointing at the front way or at a middle way. A design that read `acc_way` on a miss would promote the wrong way. Neighbouring sets are probed after each access, idle cycles carry random hit and way values, and a long random mix runs against a reference model in the bench. A set decode that spilled into the wrong entry, or an update that ignored the strobe, would show up as a ranking mismatch or a duplicated way.

// File: rtl/lru_track_pkg.sv
package lru_track_pkg;
  localparam int unsigned DEF_SETS = 16;
  localparam int unsigned DEF_WAYS = 4;

  typedef enum logic {
    ACC_MISS = 1'b0,
    ACC_HIT  = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/lru_move_front.sv
// Move-to-front rewrite of one recency list; index 0 is the most recent rank.
module lru_move_front #(
  parameter int WAYS = 4,
  localparam int IW = $clog2(WAYS),
  localparam int LW = WAYS * IW
) (
  input  logic [LW-1:0] cur_list,
  input  logic          use_hit,
  input  logic [IW-1:0] hit_way,
  output logic [LW-1:0] nxt_list
);
  logic [IW-1:0]   target;
  logic [WAYS-1:0] at_rank;
  logic [WAYS-1:0] at_or_behind;

  assign target = use_hit ? hit_way : cur_list[(WAYS-1)*IW +: IW];

  for (genvar r = 0; r < WAYS; r++) begin : g_match
    assign at_rank[r] = (cur_list[r*IW +: IW] == target);
  end

  // at_or_behind[r]: the target sits at rank r or a later rank
  assign at_or_behind[WAYS-1] = at_rank[WAYS-1];
  for (genvar r = WAYS - 2; r >= 0; r--) begin : g_scan
    assign at_or_behind[r] = at_rank[r] | at_or_behind[r+1];
  end

  assign nxt_list[IW-1:0] = target;
  for (genvar r = 1; r < WAYS; r++) begin : g_shift
    assign nxt_list[r*IW +: IW] = at_or_behind[r] ? cur_list[(r-1)*IW +: IW]
                                                  : cur_list[r*IW +: IW];
  end
endmodule

// File: rtl/lru_list_store.sv
// One recency list register per set, read asynchronously, written on strobe.
module lru_list_store #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SW = $clog2(SETS),
  localparam int IW = $clog2(WAYS),
  localparam int LW = WAYS * IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic [LW-1:0] wr_list,
  input  logic [SW-1:0] rd_set,
  output logic [LW-1:0] rd_list
);
  function automatic logic [LW-1:0] ident_list();
    logic [LW-1:0] r;
    r = '0;
    for (int k = 0; k < WAYS; k++) r[k*IW +: IW] = IW'(k);
    return r;
  endfunction

  localparam logic [LW-1:0] IDENT = ident_list();

  logic [LW-1:0] lists [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lists[s] <= IDENT;
      end else if (wr_en && (wr_set == SW'(s))) begin
        lists[s] <= wr_list;
      end
    end
  end

  always_comb begin
    rd_list = IDENT;
    for (int s = 0; s < SETS; s++) begin
      if (rd_set == SW'(s)) rd_list = lists[s];
    end
  end
endmodule

// File: rtl/lru_order_tracker.sv
module lru_order_tracker
  import lru_track_pkg::*;
#(
  parameter int SETS = DEF_SETS,
  parameter int WAYS = DEF_WAYS,
  localparam int SW = $clog2(SETS),
  localparam int IW = $clog2(WAYS),
  localparam int LW = WAYS * IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [SW-1:0] acc_set,
  input  logic          acc_hit,
  input  logic [IW-1:0] acc_way,
  output logic [IW-1:0] victim_way,
  output logic [LW-1:0] set_order
);
  acc_kind_e     kind;
  logic [LW-1:0] cur_list;
  logic [LW-1:0] nxt_list;

  assign kind = acc_kind_e'(acc_hit);

  lru_list_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_valid),
    .wr_set  (acc_set),
    .wr_list (nxt_list),
    .rd_set  (acc_set),
    .rd_list (cur_list)
  );

  lru_move_front #(.WAYS(WAYS)) u_mtf (
    .cur_list (cur_list),
    .use_hit  (kind == ACC_HIT),
    .hit_way  (acc_way),
    .nxt_list (nxt_list)
  );

  assign victim_way = cur_list[(WAYS-1)*IW +: IW];
  assign set_order  = cur_list;
endmodule

// File: rtl/lru_order_tracker_chk.sv
module lru_order_tracker_chk #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SW = $clog2(SETS),
  localparam int IW = $clog2(WAYS),
  localparam int LW = WAYS * IW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [SW-1:0] acc_set,
  input logic          acc_hit,
  input logic [IW-1:0] acc_way,
  input logic [IW-1:0] victim_way,
  input logic [LW-1:0] set_order
);
  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < WAYS; k++) seen[set_order[k*IW +: IW]] = 1'b1;
  end

  p_hit_to_front_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=>
      ((acc_set != $past(acc_set)) || (set_order[IW-1:0] == $past(acc_way))));

  p_victim_to_front_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=>
      ((acc_set != $past(acc_set)) || (set_order[IW-1:0] == $past(victim_way))));

  p_front_hit_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit && (acc_way == set_order[IW-1:0])) |=>
      ((acc_set != $past(acc_set)) || $stable(set_order)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ((acc_set != $past(acc_set)) || $stable(set_order)));

  p_permutation_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&seen));
endmodule

bind lru_order_tracker lru_order_tracker_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (.*);

// File: tb/tb_lru_order_tracker.sv
`timescale 1ns/1ps
module tb_lru_order_tracker;
  localparam int SETS = 16;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [3:0] acc_set = '0;
  logic       acc_hit = 1'b0;
  logic [1:0] acc_way = '0;
  logic [1:0] victim_way;
  logic [7:0] set_order;

  int total = 0;
  int bad = 0;

  int mdl [SETS][WAYS];

  logic [7:0] q_order [$];
  logic [1:0] q_vic [$];
  string      q_tag [$];

  always #2 clk = ~clk;

  lru_order_tracker #(.SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_way(acc_way), .victim_way(victim_way),
    .set_order(set_order)
  );

  function automatic logic [7:0] pack_set(int s);
    logic [7:0] r;
    for (int k = 0; k < WAYS; k++) r[k*2 +: 2] = 2'(mdl[s][k]);
    return r;
  endfunction

  function automatic void model_update(int s, bit hit, int way);
    int p;
    int t;
    p = WAYS - 1;
    if (hit) for (int k = 0; k < WAYS; k++) if (mdl[s][k] == way) p = k;
    t = mdl[s][p];
    for (int k = p; k > 0; k--) mdl[s][k] = mdl[s][k-1];
    mdl[s][0] = t;
  endfunction

  task automatic expect_now(int s, string tag);
    q_order.push_back(pack_set(s));
    q_vic.push_back(2'(mdl[s][WAYS-1]));
    q_tag.push_back(tag);
  endtask

  task automatic probe(int s, string tag);
    @(negedge clk);
    acc_valid = 1'b0;
    acc_set = 4'(s);
    expect_now(s, tag);
  endtask

  task automatic access(int s, bit hit, int way, string tag);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_set = 4'(s);
    acc_hit = hit;
    acc_way = 2'(way);
    expect_now(s, {tag, "/R2 pre-edge"});
    @(negedge clk);
    acc_valid = 1'b0;
    model_update(s, hit, way);
    expect_now(s, tag);
  endtask

  // monitor: compares outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_order.size() > 0) begin
        logic [7:0] eo;
        logic [1:0] ev;
        logic [3:0] seen;
        string tg;
        eo = q_order.pop_front();
        ev = q_vic.pop_front();
        tg = q_tag.pop_front();
        total++;
        if (set_order !== eo) begin
          bad++;
          $display("FAIL %s (R9 order) actual=%h expected=%h", tg, set_order, eo);
        end
        total++;
        if (victim_way !== ev) begin
          bad++;
          $display("FAIL %s (R2 victim) actual=%0d expected=%0d", tg, victim_way, ev);
        end
        seen = '0;
        for (int k = 0; k < WAYS; k++) seen[set_order[k*2 +: 2]] = 1'b1;
        total++;
        if (seen !== 4'hF) begin
          bad++;
          $display("FAIL %s (R8 permutation) actual=%b expected=1111", tg, seen);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) mdl[s][k] = k;

    // reset held with a live strobe must not disturb the reset ranking
    acc_valid = 1'b1;
    acc_hit = 1'b1;
    acc_way = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    acc_valid = 1'b0;

    for (int s = 0; s < SETS; s++) probe(s, "R1 reset ranking");

    // fixed sequence on set 5
    access(5, 1'b1, 2, "R3 hit2 from 0123");
    access(5, 1'b1, 1, "R3 hit1 from 2013");
    access(5, 1'b0, 2, "R4 miss with acc_way=2 ignored");
    access(5, 1'b1, 3, "R5 hit on front way");
    probe(4, "R7 neighbour 4 untouched");
    probe(6, "R7 neighbour 6 untouched");
    probe(5, "R3/R4 set 5 after sequence");

    // miss where acc_way names the front way
    access(9, 1'b1, 1, "R3 hit1 on set 9");
    access(9, 1'b0, 1, "R4 miss with acc_way at front");
    access(9, 1'b0, 0, "R4 second miss");

    // idle cycles carrying junk hit/way
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
      acc_set = 4'(9);
      acc_hit = i[0];
      acc_way = 2'(i);
    end
    probe(9, "R6 idle leaves set 9 unchanged");

    // random mix
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int s;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      s = int'(lf[3:0]);
      access(s, lf[4] | lf[9], int'(lf[6:5]), lf[4] | lf[9] ? "R3 random hit" : "R4 random miss");
      if (i % 16 == 0) probe((s + 1) % SETS, "R7 random neighbour");
    end
    for (int s = 0; s < SETS; s++) probe(s, "R7 final sweep");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule